// File: doc/BRIEF.md
# Fast-Infrared Receive Byte Stuffer

This block sits on the receive path of a 4 Mbps infrared link, between the demodulator that produces decoded frame bytes and the receive buffer. Each byte arriving from the demodulator may carry a frame-start mark, a frame-end mark, both, or neither. The block turns this into a plain byte stream in which frame edges are shown by a flag character, 0x7E. It writes one flag before the first byte of a frame and one after its last byte. No CRC is checked and no frame is validated, so checksum bytes are handled like any other payload byte.

The flag must stay unique in a stream that a host may read in chunks cut at arbitrary points. For that reason, three reserved values are escaped: the escape character 0x7D, the flag 0x7E and 0x7F. Each is sent as the escape byte followed by the original byte XOR 0x20. Both sides use a valid/ready handshake. The output holds its byte under backpressure. A stalled escape pair blocks new input until the pair's second byte has left.

Top module: `firrx_stuffer`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: A data byte outside 0x7D..0x7F with neither mark (0x7C and 0x80 included) is emitted as exactly that byte.
- R3: A byte with the start mark (in_sof=1) is preceded by one 0x7E in the output.
- R4: A byte with the end mark (in_eof=1) is followed by one 0x7E, even when no start mark came before it.
- R5: Data byte 0x7D is emitted as 0x7D then 0x5D.
- R6: Data byte 0x7E is emitted as 0x7D then 0x5E.
- R7: Data byte 0x7F is emitted as 0x7D then 0x5F.
- R8: While out_valid=1 and out_ready=0, out_valid stays 1 and out_data is unchanged in the next cycle.
- R9: While the escape byte 0x7D is on the output, in_ready is 0, so no new byte is taken until the second byte of the pair has been accepted.
- R10: Outside of an escape pair, the output never holds a raw 0x7F, and every accepted 0x7D is followed directly by a valid byte in 0x5D..0x5F.
- R11: Frames may follow back to back: a one-byte frame (start and end on the same beat) gives 0x7E, byte, 0x7E, and the next frame adds its own leading 0x7E.
- R12: With out_ready held at 1, unescaped bytes without marks are accepted on consecutive cycles with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Demodulator byte valid |
| in_ready | output | 1 | Block can take the byte this cycle |
| in_data | input | DATA_W | Decoded frame byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Buffer accepts the output byte |
| out_data | output | DATA_W | Stuffed byte toward the buffer |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, flag 0x7E, escape 0x7D, a reserved range of three values starting at 0x7D, and mask 0x20. With these values it can reach each of the three escape cases and both neighbours of the reserved range. It drives directed streams for single bytes, whole frames, orphan end marks and back-to-back one-byte frames. It also holds an escape pair stalled with a new byte waiting at the input. Finally, a long mixed stream is run with out_ready toggling pseudo-randomly, so that stalls land on flags, prefixes and data bytes alike.

// File: rtl/firrx_pkg.sv
package firrx_pkg;

    typedef enum logic [1:0] {
        PH_LEAD   = 2'd0,
        PH_PREFIX = 2'd1,
        PH_BODY   = 2'd2,
        PH_TRAIL  = 2'd3
    } phase_e;

    typedef struct packed {
        logic lead;
        logic trail;
        logic rsv;
    } beat_flags_t;

    function automatic phase_e first_phase(input beat_flags_t f);
        if (f.lead)     return PH_LEAD;
        else if (f.rsv) return PH_PREFIX;
        else            return PH_BODY;
    endfunction

    function automatic phase_e next_phase(input phase_e ph, input beat_flags_t f);
        case (ph)
            PH_LEAD:   return f.rsv ? PH_PREFIX : PH_BODY;
            PH_PREFIX: return PH_BODY;
            default:   return PH_TRAIL;
        endcase
    endfunction

    function automatic logic is_last(input phase_e ph, input beat_flags_t f);
        return (ph == PH_TRAIL) || ((ph == PH_BODY) && !f.trail);
    endfunction

endpackage

// File: rtl/firrx_classify.sv
module firrx_classify #(
    parameter int unsigned          DATA_W   = 8,
    parameter logic [DATA_W-1:0]    RSV_BASE = 8'h7D,
    parameter int unsigned          RSV_N    = 3,
    parameter logic [DATA_W-1:0]    FLIP     = 8'h20
) (
    input  logic [DATA_W-1:0] byte_i,
    output logic              rsv_o,
    output logic [DATA_W-1:0] coded_o
);
    logic [RSV_N-1:0] hit;

    for (genvar g = 0; g < RSV_N; g++) begin : g_cmp
        assign hit[g] = (byte_i == (RSV_BASE + DATA_W'(g)));
    end

    assign rsv_o   = |hit;
    assign coded_o = rsv_o ? (byte_i ^ FLIP) : byte_i;
endmodule

// File: rtl/firrx_seq.sv
module firrx_seq
    import firrx_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic              in_rsv,
    input  logic [DATA_W-1:0] in_coded,
    output logic              in_ready,
    input  logic              out_ready,
    output logic              busy_o,
    output phase_e            phase_o,
    output logic [DATA_W-1:0] held_o
);
    logic              busy_q;
    phase_e            phase_q;
    beat_flags_t       flags_q;
    logic [DATA_W-1:0] data_q;
    beat_flags_t       new_flags;
    logic              last;
    logic              accept;
    logic              fire;

    assign new_flags = '{lead: in_sof, trail: in_eof, rsv: in_rsv};
    assign last      = is_last(phase_q, flags_q);
    assign fire      = busy_q && out_ready;
    assign in_ready  = !busy_q || (last && out_ready);
    assign accept    = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            phase_q <= PH_LEAD;
            flags_q <= '0;
            data_q  <= '0;
        end else if (accept) begin
            busy_q  <= 1'b1;
            flags_q <= new_flags;
            data_q  <= in_coded;
            phase_q <= first_phase(new_flags);
        end else if (fire) begin
            if (last) busy_q  <= 1'b0;
            else      phase_q <= next_phase(phase_q, flags_q);
        end
    end

    assign busy_o  = busy_q;
    assign phase_o = phase_q;
    assign held_o  = data_q;
endmodule

// File: rtl/firrx_out_mux.sv
module firrx_out_mux
    import firrx_pkg::*;
#(
    parameter int unsigned       DATA_W    = 8,
    parameter logic [DATA_W-1:0] FLAG_CHAR = 8'h7E,
    parameter logic [DATA_W-1:0] ESC_CHAR  = 8'h7D
) (
    input  logic              busy,
    input  phase_e            phase,
    input  logic [DATA_W-1:0] held,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    always_comb begin
        out_data = '0;
        if (busy) begin
            case (phase)
                PH_PREFIX: out_data = ESC_CHAR;
                PH_BODY:   out_data = held;
                default:   out_data = FLAG_CHAR;
            endcase
        end
    end
    assign out_valid = busy;
endmodule

// File: rtl/firrx_stuffer.sv
module firrx_stuffer
    import firrx_pkg::*;
#(
    parameter int unsigned       DATA_W    = 8,
    parameter logic [DATA_W-1:0] FLAG_CHAR = 8'h7E,
    parameter logic [DATA_W-1:0] ESC_CHAR  = 8'h7D,
    parameter logic [DATA_W-1:0] RSV_BASE  = 8'h7D,
    parameter int unsigned       RSV_N     = 3,
    parameter logic [DATA_W-1:0] FLIP      = 8'h20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);
    logic              rsv;
    logic [DATA_W-1:0] coded;
    logic              busy;
    phase_e            phase;
    logic [DATA_W-1:0] held;

    firrx_classify #(
        .DATA_W(DATA_W), .RSV_BASE(RSV_BASE), .RSV_N(RSV_N), .FLIP(FLIP)
    ) cls_i (
        .byte_i(in_data), .rsv_o(rsv), .coded_o(coded)
    );

    firrx_seq #(.DATA_W(DATA_W)) seq_i (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
        .in_rsv(rsv), .in_coded(coded), .in_ready(in_ready),
        .out_ready(out_ready),
        .busy_o(busy), .phase_o(phase), .held_o(held)
    );

    firrx_out_mux #(
        .DATA_W(DATA_W), .FLAG_CHAR(FLAG_CHAR), .ESC_CHAR(ESC_CHAR)
    ) mux_i (
        .busy(busy), .phase(phase), .held(held),
        .out_valid(out_valid), .out_data(out_data)
    );
endmodule

// File: rtl/firrx_stuffer_chk.sv
module firrx_stuffer_chk #(
    parameter int unsigned       DATA_W    = 8,
    parameter logic [DATA_W-1:0] FLAG_CHAR = 8'h7E,
    parameter logic [DATA_W-1:0] ESC_CHAR  = 8'h7D,
    parameter logic [DATA_W-1:0] RSV_BASE  = 8'h7D,
    parameter int unsigned       RSV_N     = 3,
    parameter logic [DATA_W-1:0] FLIP      = 8'h20
) (
    input logic              clk,
    input logic              rst,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data
);
    localparam int LO = int'(RSV_BASE);
    localparam int HI = int'(RSV_BASE) + int'(RSV_N) - 1;

    logic [DATA_W-1:0] unflip;
    logic              unflip_rsv;
    logic              raw_rsv;
    assign unflip     = out_data ^ FLIP;
    assign unflip_rsv = (int'(unflip) >= LO) && (int'(unflip) <= HI);
    assign raw_rsv    = (int'(out_data) >= LO) && (int'(out_data) <= HI);

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R9
    pair_block_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_data == ESC_CHAR |-> !in_ready);

    // R10
    prefix_follow_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && out_data == ESC_CHAR |=> out_valid && unflip_rsv);

    // R10
    no_raw_rsv_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !raw_rsv || out_data == ESC_CHAR || out_data == FLAG_CHAR);
endmodule

bind firrx_stuffer firrx_stuffer_chk #(
    .DATA_W(DATA_W), .FLAG_CHAR(FLAG_CHAR), .ESC_CHAR(ESC_CHAR),
    .RSV_BASE(RSV_BASE), .RSV_N(RSV_N), .FLIP(FLIP)
) chk_i (
    .clk(clk), .rst(rst), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/firrx_stuffer_tb.sv
module firrx_stuffer_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic       in_sof = 1'b0;
    logic       in_eof = 1'b0;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [7:0] out_data;

    int total = 0;
    int bad = 0;
    bit done = 0;
    bit rnd_rdy = 0;
    int waits = 0;
    logic [15:0] lfsr = 16'hACE1;

    logic [7:0] got [256];
    int got_n = 0;
    logic [7:0] exp_q [256];
    int exp_n = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    firrx_stuffer dut_i (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    always @(negedge clk) begin
        if (!rst && out_valid && out_ready && got_n < 256) begin
            got[got_n] = out_data;
            got_n = got_n + 1;
        end
    end

    always @(posedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (rnd_rdy) out_ready <= lfsr[3] | lfsr[7];
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic clear_logs();
        got_n = 0;
        exp_n = 0;
    endtask

    task automatic push(input logic [7:0] b);
        exp_q[exp_n] = b;
        exp_n++;
    endtask

    task automatic send(input logic [7:0] b, input bit s, input bit e);
        @(posedge clk); #1;
        in_valid = 1'b1; in_data = b; in_sof = s; in_eof = e;
        forever begin
            @(negedge clk);
            if (in_ready) break;
            waits++;
        end
        @(posedge clk); #1;
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    task automatic drain_and_compare(input string req);
        for (int i = 0; i < 400 && got_n < exp_n; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(got_n == exp_n, {req, " count"}, got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++)
            chk(got[i] == exp_q[i], req, got[i], exp_q[i]);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    endtask

    task automatic t_frame();
        clear_logs();
        send(8'h11, 1, 0); send(8'h7C, 0, 0); send(8'h80, 0, 0); send(8'h33, 0, 1);
        push(8'h7E); push(8'h11); push(8'h7C); push(8'h80); push(8'h33); push(8'h7E);
        drain_and_compare("R2 R3 R4 frame");
    endtask

    task automatic t_esc(input logic [7:0] b, input logic [7:0] second, input string req);
        clear_logs();
        send(b, 0, 0);
        push(8'h7D); push(second);
        drain_and_compare(req);
    endtask

    task automatic t_orphan_eof();
        clear_logs();
        send(8'h44, 0, 1);
        push(8'h44); push(8'h7E);
        drain_and_compare("R4 orphan end");
    endtask

    task automatic t_back2back();
        clear_logs();
        send(8'hA5, 1, 1); send(8'h5A, 1, 1);
        push(8'h7E); push(8'hA5); push(8'h7E); push(8'h7E); push(8'h5A); push(8'h7E);
        drain_and_compare("R11 back to back");
    endtask

    task automatic t_stall();
        clear_logs();
        out_ready = 1'b0;
        send(8'h7E, 0, 0);
        @(posedge clk); #1;
        in_valid = 1'b1; in_data = 8'h12;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(out_valid == 1'b1, "R8 valid held", out_valid, 1);
            chk(out_data == 8'h7D, "R8 data held", out_data, 8'h7D);
            chk(in_ready == 1'b0, "R9 input blocked", in_ready, 0);
        end
        @(posedge clk); #1;
        out_ready = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b0, "R9 input blocked at prefix", in_ready, 0);
        @(negedge clk);
        chk(out_data == 8'h5E, "R6 second of pair", out_data, 8'h5E);
        chk(in_ready == 1'b1, "R9 input free after pair", in_ready, 1);
        @(posedge clk); #1;
        in_valid = 1'b0;
        push(8'h7D); push(8'h5E); push(8'h12);
        drain_and_compare("R9 stalled pair");
    endtask

    task automatic t_throughput();
        clear_logs();
        waits = 0;
        @(posedge clk); #1;
        for (int i = 0; i < 6; i++) begin
            in_valid = 1'b1; in_data = 8'h20 + 8'(i);
            @(negedge clk);
            if (!in_ready) waits++;
            @(posedge clk); #1;
            push(8'h20 + 8'(i));
        end
        in_valid = 1'b0;
        chk(waits == 0, "R12 no gaps", waits, 0);
        drain_and_compare("R12 stream");
    endtask

    task automatic t_random();
        logic [15:0] r = 16'h1D2B;
        logic [7:0]  b;
        clear_logs();
        rnd_rdy = 1;
        for (int i = 0; i < 40; i++) begin
            r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
            b = r[7:0];
            if (r[9:8] == 2'b00) b = 8'h7D + 8'(r[11:10] % 3);
            if (i % 8 == 0) push(8'h7E);
            if (b >= 8'h7D && b <= 8'h7F) begin
                push(8'h7D);
                push(b ^ 8'h20);
            end else begin
                push(b);
            end
            if (i % 8 == 7) push(8'h7E);
            send(b, (i % 8 == 0), (i % 8 == 7));
        end
        drain_and_compare("R10 mixed stream");
        rnd_rdy = 0;
        @(posedge clk); #1;
        out_ready = 1'b1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_frame();
        t_esc(8'h7D, 8'h5D, "R5 escape 7D");
        t_esc(8'h7E, 8'h5E, "R6 escape 7E");
        t_esc(8'h7F, 8'h5F, "R7 escape 7F");
        t_orphan_eof();
        t_back2back();
        t_stall();
        t_throughput();
        t_random();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog all-requirements actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule